// File: doc/BRIEF.md
# Hardware/Software Counting Semaphore

This block holds an 8-bit counting semaphore that paces a command-processing engine against the software that feeds it work. Software raises the count by writing an amount into a write-only field of the semaphore register. The engine asks for one count per unit of work through a request/grant handshake. When the count is zero the request is refused and a stall output tells the engine to wait until software adds more.

The register sits on a simple register bus and decodes four aliases selected by byte offset bits 3:2. Offset 0x0 is the plain register, 0x4 is the set alias, 0x8 is the clear alias and 0xC is the toggle alias. A software add and an engine decrement that land in the same clock are merged into one update, so neither is lost. A clear that lands with a decrement wins. Reads return the count in bits 23:16 from any alias.

Top module: `sema_reg`

## Requirements
- R1: After reset the count is zero, so a read returns 0x00000000.
- R2: A read at any of the four aliases returns the count in bits 23:16. Every other bit reads as zero, including the increment field in bits 7:0.
- R3: A write at offset 0x0 adds the value in bits 7:0 of the write data to the count.
- R4: A write at the set alias (offset 0x4) adds its bits 7:0 exactly like a write at offset 0x0.
- R5: A write at the toggle alias (offset 0xC) leaves the count unchanged.
- R6: When decReq is high and the count is nonzero, decGrant is high and the count drops by one at the next clock edge.
- R7: When decReq is high and the count is zero, decStall is high, decGrant is low, and the count stays zero.
- R8: An add and a granted decrement in the same cycle change the count by the added amount minus one. Adding 2 gives a net change of +1.
- R9: An add that would take the count above 255 leaves it at 255 and never wraps. Any decrement in the same cycle is applied before the limit.
- R10: A write at the clear alias (offset 0x8) clears every count bit whose position holds a 1 in bits 7:0 of the write data. Writing 0xFF sets the count to zero.
- R11: A clear-alias write with a nonzero bits 7:0 blocks decGrant in that cycle. The count then becomes the masked value, with no decrement applied.
- R12: decGrant and decStall are combinational. They answer a request in the same cycle, based on the count held at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register access valid this cycle |
| regWrite | input | 1 | 1 = write access, 0 = read access |
| regAddr | input | 4 | Byte offset; bits 3:2 select base, set, clear or toggle alias |
| regWdata | input | 32 | Write data; bits 7:0 carry the add amount or the clear mask |
| regRdata | output | 32 | Read data; count in bits 23:16 during a read, zero otherwise |
| decReq | input | 1 | Engine asks to consume one count |
| decGrant | output | 1 | Decrement accepted this cycle |
| decStall | output | 1 | Request refused because the count is zero |

## Verification
The checker watches several rules on every cycle:
- grant and stall are never high together;
- a granted decrement with no bus write lowers the count by exactly one;
- a full count holds at 255 when nothing can reduce it;
- a toggle write leaves the count untouched;
- a clear write with a nonzero mask blocks the grant;
- read data never sets bits outside the count field.

The exact arithmetic comes only from the bench's sweeps. These cover saturation across every add amount, the merged add-and-decrement result, and the masked clear across every mask value. The sweeps start from a spread of initial counts.

// File: rtl/sema_pkg.sv
package sema_pkg;

  // Alias selected by byte offset bits [3:2]
  typedef enum logic [1:0] {
    ALIAS_BASE = 2'd0,
    ALIAS_SET  = 2'd1,
    ALIAS_CLR  = 2'd2,
    ALIAS_TOG  = 2'd3
  } aliasSel_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic addEn;   // add operand to count
    logic clrEn;   // clear count bits under operand mask
    logic decEn;   // granted hardware decrement
    logic rdEn;    // drive count onto read data
  } semStrobe_t;

endpackage

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int INC_LSB   = 0,
  parameter int ALIAS_LSB = 2
) (
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              decReq,
  input  logic              cntZero,
  output semStrobe_t        strobe,
  output logic [CNT_W-1:0]  opVal,
  output logic              decGrant,
  output logic              decStall
);

  aliasSel_e        aliasSel;
  logic             wrHit;
  logic             fieldNonZero;
  logic             addAlias;
  logic             clrHit;

  assign aliasSel     = aliasSel_e'(regAddr[ALIAS_LSB +: 2]);
  assign wrHit        = regSel && regWrite;
  assign opVal        = regWdata[INC_LSB +: CNT_W];
  assign fieldNonZero = |opVal;

  // Base and set aliases both add; toggle alias is decoded and dropped
  always_comb begin
    addAlias = 1'b0;
    unique case (aliasSel)
      ALIAS_BASE: addAlias = 1'b1;
      ALIAS_SET:  addAlias = 1'b1;
      ALIAS_CLR:  addAlias = 1'b0;
      ALIAS_TOG:  addAlias = 1'b0;
      default:    addAlias = 1'b0;
    endcase
  end

  assign clrHit = wrHit && (aliasSel == ALIAS_CLR) && fieldNonZero;

  // Grant depends on the count held now; a clear in the same cycle wins
  assign decGrant = decReq && !cntZero && !clrHit;
  assign decStall = decReq && cntZero;

  always_comb begin
    strobe       = '0;
    strobe.addEn = wrHit && addAlias && fieldNonZero;
    strobe.clrEn = clrHit;
    strobe.decEn = decGrant;
    strobe.rdEn  = regSel && !regWrite;
  end

endmodule

// File: rtl/sema_dp.sv
module sema_dp
  import sema_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 32,
  parameter int VAL_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  semStrobe_t        strobe,
  input  logic [CNT_W-1:0]  opVal,
  output logic [CNT_W-1:0]  count,
  output logic              cntZero,
  output logic [DATA_W-1:0] rdData
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [SUM_W-1:0] sumWide;
  logic [SUM_W-1:0] afterDec;
  logic [CNT_W-1:0] mergedVal;
  logic [CNT_W-1:0] nextCount;

  // Merge add and decrement in one step, then saturate
  always_comb begin
    sumWide  = {1'b0, count} + (strobe.addEn ? {1'b0, opVal} : '0);
    afterDec = sumWide - (strobe.decEn ? SUM_W'(1) : '0);
    if (afterDec > CNT_MAX) begin
      mergedVal = CNT_MAX[CNT_W-1:0];
    end else begin
      mergedVal = afterDec[CNT_W-1:0];
    end
  end

  always_comb begin
    if (strobe.clrEn) begin
      nextCount = count & ~opVal;
    end else begin
      nextCount = mergedVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      count <= nextCount;
    end
  end

  assign cntZero = (count == '0);

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) begin
      rdData[VAL_LSB +: CNT_W] = count;
    end
  end

endmodule

// File: rtl/sema_reg.sv
module sema_reg
  import sema_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int INC_LSB   = 0,
  parameter int VAL_LSB   = 16,
  parameter int ALIAS_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              decReq,
  output logic              decGrant,
  output logic              decStall
);

  semStrobe_t       strobe;
  logic [CNT_W-1:0] opVal;
  logic [CNT_W-1:0] semCount;
  logic             cntZero;

  sema_ctrl #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INC_LSB(INC_LSB), .ALIAS_LSB(ALIAS_LSB)
  ) u_ctrl (
    .regSel   (regSel),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .decReq   (decReq),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .opVal    (opVal),
    .decGrant (decGrant),
    .decStall (decStall)
  );

  sema_dp #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .VAL_LSB(VAL_LSB)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opVal   (opVal),
    .count   (semCount),
    .cntZero (cntZero),
    .rdData  (regRdata)
  );

endmodule

// File: rtl/sema_reg_chk.sv
module sema_reg_chk #(
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int INC_LSB   = 0,
  parameter int VAL_LSB   = 16,
  parameter int ALIAS_LSB = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              decReq,
  input logic              decGrant,
  input logic              decStall,
  input logic [CNT_W-1:0]  semCount
);

  localparam logic [CNT_W-1:0]  FULL     = '1;
  localparam logic [DATA_W-1:0] VAL_MASK = DATA_W'(FULL) << VAL_LSB;

  logic wrAny;
  logic clrWr;
  logic togWr;

  assign wrAny = regSel && regWrite;
  assign clrWr = wrAny && (regAddr[ALIAS_LSB +: 2] == 2'd2)
                 && (regWdata[INC_LSB +: CNT_W] != '0);
  assign togWr = wrAny && (regAddr[ALIAS_LSB +: 2] == 2'd3);

  // R7: never grant and stall together
  a_r7_grant_stall_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(decGrant && decStall));

  // R6: a lone granted decrement lowers the count by exactly one
  a_r6_single_dec: assert property (@(posedge clk) disable iff (!rstN)
    (decGrant && !wrAny) |=> (semCount == $past(semCount) - CNT_W'(1)));

  // R9: a full count stays full when nothing can reduce it
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (semCount == FULL && !clrWr && !decGrant) |=> (semCount == FULL));

  // R5: a toggle write with no engine request leaves the count alone
  a_r5_toggle_noop: assert property (@(posedge clk) disable iff (!rstN)
    (togWr && !decReq) |=> $stable(semCount));

  // R11: clear with nonzero mask blocks the grant
  a_r11_clear_blocks: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |-> !decGrant);

  // R2: no read-data bit outside the count field is ever set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdata & ~VAL_MASK) == '0));

endmodule

bind sema_reg sema_reg_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .INC_LSB(INC_LSB), .VAL_LSB(VAL_LSB), .ALIAS_LSB(ALIAS_LSB)
) i_sema_reg_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .regWrite (regWrite),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .decReq   (decReq),
  .decGrant (decGrant),
  .decStall (decStall),
  .semCount (semCount)
);

// File: tb/test_sema_reg.sv
module test_sema_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrite = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        decReq = 1'b0;
  logic        decGrant;
  logic        decStall;

  int nChecks = 0;
  int nFails  = 0;
  logic sGrant, sStall;

  sema_reg i_sema_reg (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .decReq(decReq), .decGrant(decGrant), .decStall(decStall)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One bus/engine cycle; grant and stall sampled mid-cycle
  task automatic doCycle(input logic sel, input logic we, input logic [3:0] addr,
                         input logic [31:0] wd, input logic req);
    @(negedge clk);
    regSel = sel; regWrite = we; regAddr = addr; regWdata = wd; decReq = req;
    #1;
    sGrant = decGrant;
    sStall = decStall;
    @(posedge clk);
    #1;
    regSel = 1'b0; regWrite = 1'b0; decReq = 1'b0; regWdata = '0;
  endtask

  task automatic readAt(input logic [3:0] addr, output logic [31:0] v);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = addr;
    #1;
    v = regRdata;
    #1;
    regSel = 1'b0;
  endtask

  task automatic loadCount(input int v);
    doCycle(1, 1, 4'h8, 32'h0000_00FF, 0);
    if (v != 0) doCycle(1, 1, 4'h0, 32'(v), 0);
  endtask

  function automatic logic [31:0] word(input int c);
    return {8'h00, 8'(c), 16'h0000};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int starts[6] = '{0, 1, 5, 128, 254, 255};
    int cstarts[3] = '{0, 8'h5A, 255};

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    readAt(4'h0, rd);
    check("R1 reset count", rd, 32'h0);

    // R2: every alias reads the count; reserved bits zero
    loadCount(8'hA7);
    for (int a = 0; a < 4; a++) begin
      readAt(4'(a * 4), rd);
      check("R2 alias read", rd, word(8'hA7));
    end

    // R4: set alias adds
    loadCount(10);
    doCycle(1, 1, 4'h4, 32'h0000_0007, 0);
    readAt(4'h0, rd);
    check("R4 set alias add", rd, word(17));

    // R5: toggle alias has no effect
    for (int v = 0; v < 256; v += 51) begin
      loadCount(40);
      doCycle(1, 1, 4'hC, 32'(v) | 32'hFFFF_FF00, 0);
      readAt(4'h0, rd);
      check("R5 toggle noop", rd, word(40));
    end

    // R6, R7, R12: decrement chain into stall
    loadCount(3);
    for (int i = 0; i < 5; i++) begin
      doCycle(0, 0, 4'h0, 32'h0, 1);
      check("R12 grant same cycle", 32'(sGrant), 32'(i < 3));
      check("R7 stall on zero", 32'(sStall), 32'(i >= 3));
      readAt(4'h0, rd);
      check("R6 count after dec", rd, word((i < 3) ? 2 - i : 0));
    end

    // R3, R8, R9: sweep add amount with and without decrement
    foreach (starts[k]) begin
      for (int a = 0; a < 256; a++) begin
        for (int d = 0; d < 2; d++) begin
          int g, e;
          loadCount(starts[k]);
          doCycle(1, 1, 4'h0, 32'(a), d[0]);
          g = (d == 1 && starts[k] != 0) ? 1 : 0;
          e = starts[k] + a - g;
          if (e > 255) e = 255;
          check("R8 grant with add", 32'(sGrant), 32'(g));
          readAt(4'h0, rd);
          check((e == 255) ? "R9 saturate" : "R3 add merge", rd, word(e));
        end
      end
    end

    // R10, R11: masked clear with optional decrement
    foreach (cstarts[k]) begin
      for (int m = 0; m < 256; m++) begin
        for (int d = 0; d < 2; d++) begin
          int g, e;
          loadCount(cstarts[k]);
          doCycle(1, 1, 4'h8, 32'(m), d[0]);
          g = (d == 1 && cstarts[k] != 0 && m == 0) ? 1 : 0;
          e = (cstarts[k] & ~m & 255) - g;
          check("R11 clear blocks grant", 32'(sGrant), 32'(g));
          readAt(4'h0, rd);
          check("R10 masked clear", rd, word(e));
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule